// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous system bus and an external asynchronous static RAM organised as 16-bit words. A bus master presents one read or write at a time (word address, write data and a two-bit byte-lane mask). The controller then produces the strobe sequence the RAM needs. It drives the address, a pair of chip enables of opposite polarity, the write and output enables, the lower and upper byte strobes, and a data bus split into output value, output-enable and input value. When the access ends it returns the captured read data and a one-cycle done pulse.

Every phase has a length in system clock cycles. Each length is worked out from a clock-period parameter and from the RAM's timing figures in nanoseconds, rounded up, and is never less than one cycle. Writes are controlled by the write enable: the output enable stays inactive for the whole write, so the RAM never drives the bus at the same time as the controller. Read data is sampled only after the address, select and output-enable access times have all elapsed.

Top module: `sram_ctl`

## Requirements
- R1: Out of reset and whenever `reqReady` is high, the pins are idle: `memCeN`=1, `memCe`=0, `memWeN`=1, `memOeN`=1 and `memDqOe`=0.
- R2: The two chip enables always switch together (`memCeN` is the inverse of `memCe`). They are active from the first cycle after acceptance until done is raised.
- R3: A request is taken only when `reqValid` and `reqReady` are both high. `reqReady` is low from the cycle after acceptance until the cycle in which `rspDone` rises. `rspDone` is high for exactly one cycle and coincides with `reqReady` returning high.
- R4: The active phase lasts WR = max(ceil(tWP/T), ceil(tDW/T), ceil(tAW/T)-1) cycles for a write and RD = max(ceil(tAA/T)-1, ceil(tOE/T)) cycles for a read, where T is the clock period. `rspDone` is high N+2 cycles after the accepting edge, where N is WR or RD.
- R5: During a write, `memWeN` is low only while both chip enables are active. `memOeN` stays high throughout the write, and the data drivers are on while `memWeN` is low.
- R6: `memWeN` returns high at least one full cycle before the address, the write data, the chip enables or the data drivers change.
- R7: `reqMask` bit 0 enables the lower lane (data bits 7:0, strobe `memLbN`) and bit 1 enables the upper lane (bits 15:8, strobe `memUbN`). A value of 1 enables a lane. A lane whose strobe stays high is not written, so a write with mask 00 leaves memory unchanged.
- R8: On a read, `memOeN` is low for RD cycles after a one-cycle address/select setup. `memDqIn` is captured at the end of the last active cycle and presented on `rspRdata` when done is high. Disabled lanes read as zero.
- R9: The data drivers are never on while `memOeN` is low. They are off for at least one cycle before any read lowers `memOeN`.
- R10: `reqValid` asserted while the controller is busy has no effect: no access is started and memory is not modified.
- R11: Address, write data and mask are latched at acceptance and held on the pins for the whole access, regardless of later changes to the request inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqMask | input | 2 | Byte-lane enables, bit 0 lower, bit 1 upper |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Read data, valid with done |
| memAddr | output | ADDR_W | RAM address |
| memCeN | output | 1 | Active-low chip enable |
| memCe | output | 1 | Active-high chip enable |
| memWeN | output | 1 | Active-low write enable |
| memOeN | output | 1 | Active-low output enable |
| memLbN | output | 1 | Active-low lower byte strobe |
| memUbN | output | 1 | Active-low upper byte strobe |
| memDqOut | output | DATA_W | Data toward the RAM |
| memDqOe | output | 1 | Enable for the data-bus drivers |
| memDqIn | input | DATA_W | Data from the RAM |

## Verification
The bench builds the controller with a 6-bit address and keeps the 45 ns timing figures on a 4 ns clock, which gives a 9-cycle write pulse and an 11-cycle read window. With only 64 words, every address can be written and read back under every lane mask, and intruding requests can be placed while the controller is busy. The bench's RAM model returns valid data only once the access times, counted in cycles, have been met, so a window one cycle short shows up as corrupted read data.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACTIVE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  // Control-to-datapath strobes; select/weLow/oeLow/drive are registered.
  typedef struct packed {
    logic load;     // latch the request (accept cycle)
    logic select;   // chip enables and enabled lane strobes active
    logic weLow;    // write enable asserted
    logic oeLow;    // output enable asserted
    logic drive;    // data-bus drivers on
    logic capture;  // sample read data at the coming edge
  } strobe_t;

  function automatic int ceilCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int WR_CYC = 9,
  parameter int RD_CYC = 11,
  parameter int CNT_W  = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    rspDone,
  output strobe_t strb
);

  phase_e state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic isWr, nextIsWr;
  logic accept;
  logic selQ, weLowQ, oeLowQ, driveQ, doneQ;

  assign accept   = reqValid && (state == PH_IDLE);
  assign reqReady = (state == PH_IDLE);
  assign rspDone  = doneQ;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    nextIsWr  = isWr;
    unique case (state)
      PH_IDLE: begin
        if (accept) begin
          nextState = PH_SETUP;
          nextIsWr  = reqWrite;
        end
      end
      PH_SETUP: begin
        nextState = PH_ACTIVE;
        nextCnt   = isWr ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);
      end
      PH_ACTIVE: begin
        if (cnt == CNT_W'(1)) nextState = PH_RECOVER;
        else                  nextCnt   = cnt - CNT_W'(1);
      end
      PH_RECOVER: nextState = PH_IDLE;
      default:    nextState = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= PH_IDLE;
      cnt    <= '0;
      isWr   <= 1'b0;
      selQ   <= 1'b0;
      weLowQ <= 1'b0;
      oeLowQ <= 1'b0;
      driveQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      state  <= nextState;
      cnt    <= nextCnt;
      isWr   <= nextIsWr;
      // pin strobes are registered from the next phase: glitch-free edges
      selQ   <= (nextState != PH_IDLE);
      weLowQ <= (nextState == PH_ACTIVE) && nextIsWr;
      oeLowQ <= (nextState == PH_ACTIVE) && !nextIsWr;
      driveQ <= nextIsWr && ((nextState == PH_ACTIVE) || (nextState == PH_RECOVER));
      doneQ  <= (state == PH_RECOVER);
    end
  end

  always_comb begin
    strb.load    = accept;
    strb.select  = selQ;
    strb.weLow   = weLowQ;
    strb.oeLow   = oeLowQ;
    strb.drive   = driveQ;
    strb.capture = (state == PH_ACTIVE) && (cnt == CNT_W'(1)) && !isWr;
  end

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memCe,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memLaneN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rspRdata
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (strb.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign memDqOe  = strb.drive;
  assign memCeN   = !strb.select;
  assign memCe    = strb.select;
  assign memWeN   = !strb.weLow;
  assign memOeN   = !strb.oeLow;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] laneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             laneQ <= '0;
      else if (strb.capture) laneQ <= maskQ[l] ? memDqIn[l*LANE_W +: LANE_W] : '0;
    end
    assign rspRdata[l*LANE_W +: LANE_W] = laneQ;
    assign memLaneN[l] = !(strb.select && maskQ[l]);
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 4,
  parameter int T_AA_NS = 45,
  parameter int T_OE_NS = 25,
  parameter int T_WP_NS = 35,
  parameter int T_AW_NS = 40,
  parameter int T_DW_NS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memCe,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int LANES  = 2;
  // write pulse: address/select lead WE by the one setup cycle
  localparam int WR_CYC = maxOf(maxOf(ceilCycles(T_WP_NS, CLK_NS), ceilCycles(T_DW_NS, CLK_NS)),
                                ceilCycles(T_AW_NS, CLK_NS) - 1);
  // read window: address/select lead OE by the one setup cycle
  localparam int RD_CYC = maxOf(ceilCycles(T_AA_NS, CLK_NS) - 1, ceilCycles(T_OE_NS, CLK_NS));
  localparam int CNT_W  = $clog2(maxOf(WR_CYC, RD_CYC) + 1);

  strobe_t strb;
  logic [LANES-1:0] laneN;

  sram_ctl_fsm #(
    .WR_CYC(WR_CYC),
    .RD_CYC(RD_CYC),
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .rspDone (rspDone),
    .strb    (strb)
  );

  sram_ctl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memCe   (memCe),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memLaneN(laneN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .rspRdata(rspRdata)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[1];

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int WR_CYC = 9,
  parameter int RD_CYC = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspDone,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memCe,
  input logic              memWeN,
  input logic              memOeN,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqOe
);

  int weRun, oeRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weRun <= 0;
      oeRun <= 0;
    end else begin
      weRun <= memWeN ? 0 : weRun + 1;
      oeRun <= memOeN ? 0 : oeRun + 1;
    end
  end

  // R1
  idle_levels_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && !memCe && memWeN && memOeN && !memDqOe));

  // R2
  ce_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    memCeN == !memCe);

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R3
  done_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> reqReady);

  // R4
  we_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weRun == WR_CYC));

  // R4
  oe_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (oeRun == RD_CYC));

  // R5
  we_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memOeN && memDqOe));

  // R6
  we_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> ($stable(memAddr) && $stable(memDqOut) && memCe && memDqOe));

  // R9
  bus_turn_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .WR_CYC(WR_CYC),
  .RD_CYC(RD_CYC)
) chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .rspDone (rspDone),
  .memAddr (memAddr),
  .memCeN  (memCeN),
  .memCe   (memCe),
  .memWeN  (memWeN),
  .memOeN  (memOeN),
  .memDqOut(memDqOut),
  .memDqOe (memDqOe)
);

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
module sram_ctl_test;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int WORDS = 1 << AW;
  localparam int CLK_NS = 4;
  localparam int T_AA = 45, T_OE = 25, T_WP = 35, T_AW = 40, T_DW = 20;

  function automatic int cdiv(input int a);
    int c;
    c = (a + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WR_LEN = mx(mx(cdiv(T_WP), cdiv(T_DW)), cdiv(T_AW) - 1);
  localparam int RD_LEN = mx(cdiv(T_AA) - 1, cdiv(T_OE));

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [1:0] reqMask = 2'b00;
  logic reqReady, rspDone;
  logic [DW-1:0] rspRdata;
  logic [AW-1:0] memAddr;
  logic memCeN, memCe, memWeN, memOeN, memLbN, memUbN, memDqOe;
  logic [DW-1:0] memDqOut;
  logic [DW-1:0] memDqIn = 16'hEEEE;

  always #2 clk = ~clk;

  sram_ctl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_NS),
    .T_AA_NS(T_AA), .T_OE_NS(T_OE), .T_WP_NS(T_WP), .T_AW_NS(T_AW), .T_DW_NS(T_DW)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspDone(rspDone), .rspRdata(rspRdata), .memAddr(memAddr), .memCeN(memCeN),
    .memCe(memCe), .memWeN(memWeN), .memOeN(memOeN), .memLbN(memLbN), .memUbN(memUbN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int nChecks = 0;
  int nFail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- RAM model with access-time enforcement ----------------
  logic [DW-1:0] ram [WORDS];
  logic [DW-1:0] shadow [WORDS];
  int selCnt = 0, oeCnt = 0, weCnt = 0;
  logic [AW-1:0] lastAddr = '0, pendAddr = '0;
  logic [DW-1:0] pendData = '0;
  logic pendLbN = 1'b1, pendUbN = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      automatic bit selAct = !memCeN && memCe;
      selCnt = (selAct && memAddr == lastAddr) ? selCnt + 1 : (selAct ? 1 : 0);
      lastAddr = memAddr;
      oeCnt = (selAct && !memOeN) ? oeCnt + 1 : 0;
      if (!memWeN) begin
        if (!selAct) chk(1'b0, "R5 write enable without select", {31'd0, selAct}, 1);
        if (!memDqOe) chk(1'b0, "R5 drivers off during write pulse", {31'd0, memDqOe}, 1);
        if (weCnt > 0 && memAddr != pendAddr) chk(1'b0, "R11 address moved in write", memAddr, pendAddr);
        weCnt++;
        pendAddr = memAddr; pendData = memDqOut; pendLbN = memLbN; pendUbN = memUbN;
      end else if (weCnt > 0) begin
        chk(weCnt == WR_LEN, "R4 write pulse length", weCnt, WR_LEN);
        chk(selAct && memAddr == pendAddr && memDqOut == pendData && memDqOe,
            "R6 hold after write enable rises", {memAddr, memDqOut}, {pendAddr, pendData});
        if (!pendLbN) ram[pendAddr][7:0]  = pendData[7:0];
        if (!pendUbN) ram[pendAddr][15:8] = pendData[15:8];
        weCnt = 0;
      end
      if (memDqOe && !memOeN) chk(1'b0, "R9 drivers on with output enable", 1, 0);
      if (selAct && !memOeN && memWeN && oeCnt * CLK_NS >= T_OE && selCnt * CLK_NS >= T_AA)
        memDqIn = {memUbN ? 8'hEE : ram[memAddr][15:8], memLbN ? 8'hEE : ram[memAddr][7:0]};
      else
        memDqIn = 16'hEEEE;
    end
  end

  // ---------------- request driver ----------------
  task automatic doReq(input bit wr, input int a, input logic [15:0] d, input logic [1:0] m,
                       input bit intrude, output logic [15:0] rd);
    int lat;
    int busyBad;
    @(negedge clk);
    chk(reqReady, "R3 ready before request", {31'd0, reqReady}, 1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = AW'(a); reqWdata = d; reqMask = m;
    @(negedge clk);
    // scramble the request inputs: the access must use the latched values (R11)
    reqValid = 1'b0; reqAddr = ~AW'(a); reqWdata = ~d; reqMask = ~m; reqWrite = ~wr;
    lat = 1;
    busyBad = 0;
    while (!rspDone && lat < 100) begin
      if (reqReady) busyBad++;
      if (intrude && lat == 3) begin
        // R10: write request offered while busy
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = AW'(a + 1); reqWdata = 16'hFFFF; reqMask = 2'b11;
      end else begin
        reqValid = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    reqValid = 1'b0;
    chk(lat == (wr ? WR_LEN : RD_LEN) + 3, "R4 accept-to-done latency", lat, (wr ? WR_LEN : RD_LEN) + 3);
    chk(busyBad == 0, "R3 ready low while busy", busyBad, 0);
    chk(reqReady, "R3 ready with done", {31'd0, reqReady}, 1);
    rd = rspRdata;
    @(negedge clk);
    chk(!rspDone, "R3 done lasts one cycle", {31'd0, rspDone}, 0);
    if (wr) begin
      if (m[0]) shadow[a][7:0]  = d[7:0];
      if (m[1]) shadow[a][15:8] = d[15:8];
    end
  endtask

  function automatic logic [15:0] expRead(input int a, input logic [1:0] m);
    return {m[1] ? shadow[a][15:8] : 8'h00, m[0] ? shadow[a][7:0] : 8'h00};
  endfunction

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    logic [15:0] rd;
    for (int i = 0; i < WORDS; i++) begin
      ram[i] = 16'h0000;
      shadow[i] = 16'h0000;
    end
    repeat (3) @(negedge clk);
    // R1: idle levels under reset and after release
    chk(memCeN && !memCe && memWeN && memOeN && !memDqOe && !rspDone,
        "R1 pins idle in reset", {memCeN, memCe, memWeN, memOeN, memDqOe, rspDone}, 6'b101100);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && memCeN && !memCe && memWeN && memOeN && !memDqOe,
        "R1 idle after reset", {reqReady, memCeN, memCe, memWeN, memOeN, memDqOe}, 6'b110110);
    // R2: chip enables only while busy, full-word write sweep
    for (int a = 0; a < WORDS; a++)
      doReq(1'b1, a, 16'((a * 257) ^ 16'hA55A), 2'b11, 1'b0, rd);
    // R8: read sweep, full mask
    for (int a = 0; a < WORDS; a++) begin
      doReq(1'b0, a, 16'h0, 2'b11, 1'b0, rd);
      chk(rd == expRead(a, 2'b11), "R8 read back full word", rd, expRead(a, 2'b11));
    end
    // R7: partial-lane writes, every mask value including 00
    for (int a = 0; a < WORDS; a++)
      doReq(1'b1, a, 16'((a * 4099) ^ 16'h3C96), 2'(a % 4), 1'b0, rd);
    for (int a = 0; a < WORDS; a++) begin
      doReq(1'b0, a, 16'h0, 2'b11, 1'b0, rd);
      chk(rd == expRead(a, 2'b11), "R7 lane-masked write result", rd, expRead(a, 2'b11));
    end
    // R8: reads with lanes disabled return zero in those lanes
    for (int a = 0; a < WORDS; a++) begin
      doReq(1'b0, a, 16'h0, 2'((a + 1) % 4), 1'b0, rd);
      chk(rd == expRead(a, 2'((a + 1) % 4)), "R8 lane-masked read", rd, expRead(a, 2'((a + 1) % 4)));
    end
    // R10: write offered while a read is busy is ignored
    doReq(1'b0, 20, 16'h0, 2'b11, 1'b1, rd);
    chk(rd == expRead(20, 2'b11), "R10 read unaffected by intruder", rd, expRead(20, 2'b11));
    doReq(1'b0, 21, 16'h0, 2'b11, 1'b0, rd);
    chk(rd == expRead(21, 2'b11), "R10 intruding write discarded", rd, expRead(21, 2'b11));
    // R9: write directly followed by read of same word
    doReq(1'b1, 33, 16'hBEEF, 2'b11, 1'b0, rd);
    doReq(1'b0, 33, 16'h0, 2'b11, 1'b0, rd);
    chk(rd == 16'hBEEF, "R9 write-then-read turnaround", rd, 16'hBEEF);
    repeat (2) @(negedge clk);
    chk(memCeN && !memCe && !memDqOe, "R2 enables released when idle", {memCeN, memCe, memDqOe}, 3'b100);
    report();
    $finish;
  end

endmodule